// File: doc/BRIEF.md
# Fetch Group Truncation Unit

This block sits at the front of a wide fetch stage. Each cycle it presents a fetch address to the instruction memory and receives an aligned group of instruction words, one word per slot. It also receives one direction prediction for the whole group. The prediction carries a slot index and a target address. From these the block registers a per-slot valid mask together with the group and its address, and it selects the next fetch address.

A predicted-taken slot ends the group. Slots above it are dropped, and the next cycle fetches at the target. The block does not look at the instruction words to check that the marked slot holds a branch. When fetch lands in the middle of a group, for example at a taken target, the slots below the entry point are also masked. A redirect from execute has priority over both the prediction and a stall. A stall freezes the fetch address and every registered output.

Top module: `fetch_trunc_unit`

## Requirements
- R1: While reset is high, at the next clock edge the fetch address becomes RESET_PC and the valid mask becomes all zeros.
- R2: In an advancing cycle with no taken prediction, every slot at or above the entry slot is marked valid. The next fetch address is the group base plus SLOTS*INSN_BYTES. The group base is the fetch address with its low log2(SLOTS*INSN_BYTES) bits cleared.
- R3: In an advancing cycle with a taken prediction at slot k, every slot above k is marked invalid.
- R4: In an advancing cycle with a taken prediction, the next fetch address is the predicted target. No address past the group is fetched in between.
- R5: Truncation depends only on the prediction inputs. The content of the instruction words, including all-zero words, has no effect on the mask or on the next address.
- R6: Slot i covers byte offset i*INSN_BYTES inside the group, and slot 0 sits at the lowest address and in the lowest bits of the group bus. The entry slot is the fetch address bits [log2(SLOTS*INSN_BYTES)-1 : log2(INSN_BYTES)]. Slots below the entry slot are invalid. If a taken slot lies below the entry slot, the mask is all zeros.
- R7: A redirect loads its address as the next fetch address and clears the valid mask at the next edge. It takes priority over the prediction and over a stall.
- R8: A stall without a redirect holds the fetch address, the valid mask, the group words and the group address unchanged.
- R9: In an advancing cycle, the registered group words equal the instruction bus input, and the registered group address equals the fetch address of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | output | PC_W | Current fetch address sent to instruction memory |
| imem_group | input | SLOTS*INSN_W | Instruction words for fetch_pc; slot 0 in the low bits |
| pred_taken | input | 1 | Prediction for this group is taken |
| pred_slot | input | log2(SLOTS) | Slot that carries the prediction |
| pred_target | input | PC_W | Predicted target address |
| stall | input | 1 | Hold fetch state |
| redir_valid | input | 1 | Redirect from execute |
| redir_pc | input | PC_W | Corrected fetch address |
| grp_insns | output | SLOTS*INSN_W | Registered instruction group |
| grp_valid | output | SLOTS | Registered per-slot valid mask |
| grp_pc | output | PC_W | Address the registered group was fetched from |

## Verification
The hardest cases to reach from the ports involve two conditions that must line up. One is a taken prediction whose slot lies below the entry slot. The other is a redirect that arrives while a stall is held and the predictor is still asserting taken. For the first, the stimulus jumps to a target in the middle of a group and then marks a lower slot taken. For the second, it holds stall for several cycles with taken noise on the prediction inputs and raises the redirect in the middle of the stall. A long run with random stall, redirect and prediction inputs then compares every output against a behavioural model on every clock.

// File: rtl/fetch_trunc_pkg.sv
package fetch_trunc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD     = 2'd0,
    STEP_ADVANCE  = 2'd1,
    STEP_REDIRECT = 2'd2
  } fetch_step_e;
endpackage

// File: rtl/ftu_step_ctrl.sv
module ftu_step_ctrl
  import fetch_trunc_pkg::*;
(
  input  logic        stall,
  input  logic        redir_valid,
  output fetch_step_e step
);
  always_comb begin
    if (redir_valid)  step = STEP_REDIRECT;
    else if (stall)   step = STEP_HOLD;
    else              step = STEP_ADVANCE;
  end
endmodule

// File: rtl/ftu_slot_mask.sv
module ftu_slot_mask #(
  parameter int SLOTS   = 4,
  parameter int SLOT_IW = $clog2(SLOTS)
) (
  input  logic [SLOT_IW-1:0] entry_slot,
  input  logic               taken,
  input  logic [SLOT_IW-1:0] taken_slot,
  output logic [SLOTS-1:0]   mask
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    localparam logic [SLOT_IW-1:0] IDX = SLOT_IW'(i);
    logic at_or_after_entry;
    logic before_cut;
    assign at_or_after_entry = (IDX >= entry_slot);
    assign before_cut        = !taken || (IDX <= taken_slot);
    assign mask[i]           = at_or_after_entry && before_cut;
  end
endmodule

// File: rtl/ftu_next_pc.sv
module ftu_next_pc #(
  parameter int PC_W        = 32,
  parameter int GROUP_LSB   = 4,
  parameter int GROUP_BYTES = 16
) (
  input  logic [PC_W-GROUP_LSB-1:0] pc_hi,
  input  logic                      taken,
  input  logic [PC_W-1:0]           target,
  output logic [PC_W-1:0]           seq_pc,
  output logic [PC_W-1:0]           next_pc
);
  logic [PC_W-1:0] base;
  assign base    = {pc_hi, {GROUP_LSB{1'b0}}};
  assign seq_pc  = base + PC_W'(GROUP_BYTES);
  assign next_pc = taken ? target : seq_pc;
endmodule

// File: rtl/fetch_trunc_unit.sv
module fetch_trunc_unit
  import fetch_trunc_pkg::*;
#(
  parameter int              SLOTS      = 4,
  parameter int              INSN_W     = 32,
  parameter int              PC_W       = 32,
  parameter int              INSN_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC   = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic [PC_W-1:0]         fetch_pc,
  input  logic [SLOTS*INSN_W-1:0] imem_group,
  input  logic                    pred_taken,
  input  logic [$clog2(SLOTS)-1:0] pred_slot,
  input  logic [PC_W-1:0]         pred_target,
  input  logic                    stall,
  input  logic                    redir_valid,
  input  logic [PC_W-1:0]         redir_pc,
  output logic [SLOTS*INSN_W-1:0] grp_insns,
  output logic [SLOTS-1:0]        grp_valid,
  output logic [PC_W-1:0]         grp_pc
);
  localparam int SLOT_IW     = $clog2(SLOTS);
  localparam int GROUP_BYTES = SLOTS * INSN_BYTES;
  localparam int BYTE_LSB    = $clog2(INSN_BYTES);
  localparam int GROUP_LSB   = $clog2(GROUP_BYTES);

  logic [PC_W-1:0]         pc_q;
  logic [SLOTS*INSN_W-1:0] ins_q;
  logic [SLOTS-1:0]        vld_q;
  logic [PC_W-1:0]         gpc_q;

  fetch_step_e         step;
  logic [SLOT_IW-1:0]  entry_slot;
  logic [SLOTS-1:0]    slot_mask;
  logic [PC_W-1:0]     seq_pc;
  logic [PC_W-1:0]     next_pc;

  assign entry_slot = pc_q[GROUP_LSB-1:BYTE_LSB];

  ftu_step_ctrl u_step (
    .stall       (stall),
    .redir_valid (redir_valid),
    .step        (step)
  );

  ftu_slot_mask #(.SLOTS(SLOTS), .SLOT_IW(SLOT_IW)) u_mask (
    .entry_slot (entry_slot),
    .taken      (pred_taken),
    .taken_slot (pred_slot),
    .mask       (slot_mask)
  );

  ftu_next_pc #(.PC_W(PC_W), .GROUP_LSB(GROUP_LSB), .GROUP_BYTES(GROUP_BYTES)) u_npc (
    .pc_hi   (pc_q[PC_W-1:GROUP_LSB]),
    .taken   (pred_taken),
    .target  (pred_target),
    .seq_pc  (seq_pc),
    .next_pc (next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= RESET_PC;
      vld_q <= '0;
      ins_q <= '0;
      gpc_q <= '0;
    end else begin
      case (step)
        STEP_REDIRECT: begin
          pc_q  <= redir_pc;
          vld_q <= '0;
        end
        STEP_ADVANCE: begin
          pc_q  <= next_pc;
          vld_q <= slot_mask;
          ins_q <= imem_group;
          gpc_q <= pc_q;
        end
        default: ;
      endcase
    end
  end

  assign fetch_pc  = pc_q;
  assign grp_insns = ins_q;
  assign grp_valid = vld_q;
  assign grp_pc    = gpc_q;

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (stall && !redir_valid) |=> ($stable(fetch_pc) && $stable(grp_valid)
                                 && $stable(grp_insns) && $stable(grp_pc)));

  p_redirect_r7: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> (fetch_pc == $past(redir_pc) && grp_valid == '0));

  p_seq_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (!stall && !redir_valid && !pred_taken) |=> (fetch_pc == $past(seq_pc)));

  p_taken_target_r4: assert property (@(posedge clk) disable iff (rst)
    (!stall && !redir_valid && pred_taken) |=> (fetch_pc == $past(pred_target)));

  p_cut_above_r3: assert property (@(posedge clk) disable iff (rst)
    (!stall && !redir_valid && pred_taken)
      |=> ((32'(grp_valid) >> (int'($past(pred_slot)) + 1)) == 0));

  p_entry_below_r6: assert property (@(posedge clk) disable iff (rst)
    (!stall && !redir_valid)
      |=> ((grp_valid & ((SLOTS'(1) << $past(entry_slot)) - SLOTS'(1))) == '0));

  p_group_capture_r9: assert property (@(posedge clk) disable iff (rst)
    (!stall && !redir_valid) |=> (grp_pc == $past(fetch_pc) && grp_insns == $past(imem_group)));
endmodule

// File: tb/fetch_trunc_unit_tb_top.sv
module fetch_trunc_unit_tb_top;
  localparam int SLOTS = 4;
  localparam int IW    = 32;
  localparam int GB    = 16;

  logic                clk = 1'b0;
  logic                rst;
  logic [31:0]         fetch_pc;
  logic [SLOTS*IW-1:0] imem_group;
  logic                pred_taken;
  logic [1:0]          pred_slot;
  logic [31:0]         pred_target;
  logic                stall;
  logic                redir_valid;
  logic [31:0]         redir_pc;
  logic [SLOTS*IW-1:0] grp_insns;
  logic [SLOTS-1:0]    grp_valid;
  logic [31:0]         grp_pc;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  bit  zmode  = 1'b0;

  logic [31:0]         m_pc;
  logic [SLOTS-1:0]    m_vld;
  logic [SLOTS*IW-1:0] m_ins;
  logic [31:0]         m_gpc;

  always #10 clk = ~clk;

  fetch_trunc_unit dut_i (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .imem_group(imem_group),
    .pred_taken(pred_taken), .pred_slot(pred_slot), .pred_target(pred_target),
    .stall(stall), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .grp_insns(grp_insns), .grp_valid(grp_valid), .grp_pc(grp_pc)
  );

  function automatic logic [SLOTS*IW-1:0] mem_group(input logic [31:0] a);
    logic [SLOTS*IW-1:0] g;
    logic [31:0] base;
    base = a & ~32'(GB - 1);
    for (int i = 0; i < SLOTS; i++)
      g[i*IW +: IW] = zmode ? 32'h0 : ((base ^ 32'hC3C30000) + 32'(i));
    return g;
  endfunction

  always_comb imem_group = mem_group(fetch_pc);

  task automatic check(input string tag, input string what,
                       input logic [SLOTS*IW-1:0] act, input logic [SLOTS*IW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "fetch_pc",  128'(fetch_pc),  128'(m_pc));
    check(tag, "grp_valid", 128'(grp_valid), 128'(m_vld));
    check(tag, "grp_insns", grp_insns,       m_ins);
    check(tag, "grp_pc",    128'(grp_pc),    128'(m_gpc));
  endtask

  task automatic cyc(input bit t, input int s, input logic [31:0] tg,
                     input bit st, input bit rv, input logic [31:0] rp, input string tag);
    logic [31:0] old;
    int off;
    pred_taken = t; pred_slot = 2'(s); pred_target = tg;
    stall = st; redir_valid = rv; redir_pc = rp;
    @(posedge clk);
    if (rv) begin
      m_pc  = rp;
      m_vld = '0;
    end else if (!st) begin
      old = m_pc;
      off = int'((old % GB) / 4);
      for (int i = 0; i < SLOTS; i++)
        m_vld[i] = (i >= off) && (!t || i <= s);
      m_ins = mem_group(old);
      m_gpc = old;
      m_pc  = t ? tg : (old - (old % GB)) + GB;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pred_taken = 0; pred_slot = 0; pred_target = 0;
    stall = 0; redir_valid = 0; redir_pc = 0;
    m_pc = 0; m_vld = 0; m_ins = 0; m_gpc = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst = 1'b0;

    repeat (3) cyc(0, 0, 0, 0, 0, 0, "R2 R9");
    for (int k = 0; k < SLOTS; k++) begin
      cyc(1, k, 32'h100 + 32'(k * 16), 0, 0, 0, "R3 R4");
      cyc(0, 0, 0, 0, 0, 0, "R4 R2");
    end
    cyc(1, 3, 32'h208, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 0, 0, "R6");
    cyc(1, 3, 32'h30C, 0, 0, 0, "R4");
    cyc(1, 1, 32'h400, 0, 0, 0, "R6 R5");
    zmode = 1'b1;
    cyc(1, 2, 32'h500, 0, 0, 0, "R5 R3");
    cyc(0, 0, 0, 0, 0, 0, "R5 R2");
    zmode = 1'b0;
    repeat (3) cyc(1, 0, 32'hBAD0, 1, 0, 0, "R8");
    cyc(1, 1, 32'hBAD0, 0, 1, 32'h604, "R7");
    cyc(0, 0, 0, 0, 0, 0, "R6 R7");
    cyc(1, 2, 32'hBAD0, 1, 0, 0, "R8");
    cyc(1, 2, 32'hBAD0, 1, 1, 32'h700, "R7");
    cyc(1, 2, 32'hBAD0, 1, 0, 0, "R8 R7");
    cyc(0, 0, 0, 0, 0, 0, "R2 R7");

    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0], int'(r[2:1]), {16'h0, r[31:18], 2'b00}, (r[5:3] == 0), (r[9:6] == 0),
          {16'h0, r[17:12], 10'h0} | 32'(r[11:10]) << 2, "R2 R3 R4 R6 R7 R8 R9");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule